// File: doc/BRIEF.md
# Accumulator Processor Core with Multi-Step Control

This block is a small stored-program processor. It keeps one 16-bit accumulator and runs every instruction as a fixed series of register transfers through an address register and a buffer register. A hardwired state machine drives the series. Memory is 4096 words of 16 bits, addressed by word. The memory sits outside the block behind a synchronous port: the address is presented in one cycle and the read data comes back in the next. The address register drives the address pins directly, and the buffer register drives the write-data pins.

An instruction word carries a 4-bit operation code in bits 15..12 and a 12-bit operand address in bits 11..0. The core provides direct load, add, subtract and store. It also has a conditional skip chosen by a 2-bit field, direct and single-level indirect jumps, a single-level indirect add, a subroutine call that writes its return address into memory, clear, byte input, byte output and halt.

The byte ports apply no back-pressure. The input side is a capture strobe: a cycle with `in_valid` high always overwrites the input register. The output side is a one-cycle strobe with no ready, so the consumer must take `out_data` in the cycle `out_valid` is high. `out_data` then keeps its value until the next output instruction.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mem_we`, `out_valid` and `halted` are low. In those cycles `mem_addr` and `out_data` are zero, and execution starts by fetching the word at address 0.
- R2: Fetch reads the word at PC and then advances PC by one, wrapping modulo 4096. Bits 15..12 of the word select the operation and bits 11..0 give the operand address X. Reads return data one cycle after the address is presented.
- R3: Opcode 1 loads M[X] into AC. Opcode 3 adds M[X] to AC and opcode 4 subtracts M[X] from AC. Both arithmetic operations wrap modulo 2^16.
- R4: Opcode 2 writes AC to M[X]. Each write holds `mem_we` high for exactly one cycle, and the core makes no other writes.
- R5: Opcode 8 adds one to PC when its condition holds. The condition is selected by bits 11..10 as a signed test on AC: 00 means AC<0, 01 means AC=0, 10 means AC>0, and 11 never skips.
- R6: Opcode 9 sets PC to X. Opcode C sets PC to bits 11..0 of M[X].
- R7: Opcode B adds M[M[X][11:0]] to AC, wrapping modulo 2^16.
- R8: Opcode 0 writes the already advanced PC, zero-extended, to M[X]. It then sets both AC and PC to X+1.
- R9: Opcode A clears AC. Opcodes D, E and F change no register and no memory word.
- R10: A cycle with `in_valid` high stores `in_data` into the 8-bit input register, and a later capture replaces an earlier one. Opcode 5 loads that register into AC with zero extension.
- R11: Opcode 6 puts AC[7:0] on `out_data` and raises `out_valid` for one cycle. `out_data` changes only together with such a strobe.
- R12: Opcode 7 raises `halted`, which stays high until reset. While halted the core makes no memory write, gives no output strobe and holds `mem_addr` steady.
- R13: An instruction takes 4 cycles with no memory operand, 6 cycles for opcodes 1, 3, 4 and C, 8 cycles for opcode B and 5 cycles for opcodes 2 and 0. `halted` rises 4 cycles after the halt instruction's fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address to memory |
| mem_wdata | output | 16 | Write data to memory |
| mem_we | output | 1 | Write enable, one cycle per write |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| in_valid | input | 1 | Capture strobe for `in_data` |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 8 | Last output byte |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bound checker watches, on every cycle, the strobe shapes that need no program context. These are single-cycle writes and output strobes, `out_data` changing only with its strobe, and the stickiness and quietness of the halted state. Everything that depends on instruction semantics can only be shown by the bench's programs, checked against a behavioural instruction model. That covers arithmetic wrap, every skip code, indirect and subroutine addressing, input capture order and the cycle count up to `halted`.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_CALL  = 4'h0, OP_LOAD = 4'h1, OP_STORE = 4'h2, OP_ADD   = 4'h3,
    OP_SUB   = 4'h4, OP_IN   = 4'h5, OP_OUT   = 4'h6, OP_HALT  = 4'h7,
    OP_SKIP  = 4'h8, OP_JMP  = 4'h9, OP_CLR   = 4'hA, OP_ADDIND = 4'hB,
    OP_JMPIND = 4'hC, OP_NOPD = 4'hD, OP_NOPE = 4'hE, OP_NOPF  = 4'hF
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_FETCH_RD, ST_DECODE, ST_OPND_RD, ST_OPND_CAP,
    ST_IND_RD, ST_IND_CAP, ST_EXEC, ST_WRITE, ST_HALTED
  } state_e;

  function automatic logic needs_operand(opcode_e op);
    return op inside {OP_LOAD, OP_ADD, OP_SUB, OP_ADDIND, OP_JMPIND};
  endfunction
endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl import acc_cpu_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e fetched_op,
  input  opcode_e cur_op,
  output state_e  state
);
  state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_FETCH:    nxt = ST_FETCH_RD;
      ST_FETCH_RD: nxt = ST_DECODE;
      ST_DECODE:   nxt = needs_operand(fetched_op) ? ST_OPND_RD : ST_EXEC;
      ST_OPND_RD:  nxt = ST_OPND_CAP;
      ST_OPND_CAP: nxt = (cur_op == OP_ADDIND) ? ST_IND_RD : ST_EXEC;
      ST_IND_RD:   nxt = ST_IND_CAP;
      ST_IND_CAP:  nxt = ST_EXEC;
      ST_EXEC: begin
        if (cur_op == OP_STORE || cur_op == OP_CALL) nxt = ST_WRITE;
        else if (cur_op == OP_HALT)                  nxt = ST_HALTED;
        else                                         nxt = ST_FETCH;
      end
      ST_WRITE:    nxt = ST_FETCH;
      ST_HALTED:   nxt = ST_HALTED;
      default:     nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu import acc_cpu_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  opcode_e           op,
  input  logic [1:0]        cond,
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] mbr,
  input  logic [IO_W-1:0]   in_byte,
  output logic [DATA_W-1:0] result,
  output logic              skip
);
  logic neg, zero;

  always_comb begin
    case (op)
      OP_LOAD:           result = mbr;
      OP_ADD, OP_ADDIND: result = ac + mbr;
      OP_SUB:            result = ac - mbr;
      OP_IN:             result = DATA_W'(in_byte);
      OP_CLR:            result = '0;
      default:           result = ac;
    endcase
  end

  assign neg  = ac[DATA_W-1];
  assign zero = (ac == '0);

  always_comb begin
    case (cond)
      2'b00:   skip = neg;
      2'b01:   skip = zero;
      2'b10:   skip = !neg && !zero;
      default: skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_io.sv
module acc_cpu_io #(
  parameter int IO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IO_W-1:0] in_data,
  input  logic            out_load,
  input  logic [IO_W-1:0] out_src,
  output logic [IO_W-1:0] in_reg,
  output logic [IO_W-1:0] out_data,
  output logic            out_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_reg    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (in_valid) in_reg <= in_data;
      if (out_load) out_data <= out_src;
      out_valid <= out_load;
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu import acc_cpu_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  input  logic [IO_W-1:0]   in_data,
  output logic              out_valid,
  output logic [IO_W-1:0]   out_data,
  output logic              halted
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);
  localparam int COND_HI = ADDR_W - 1;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] ac, mbr, ir, alu_res;
  logic [IO_W-1:0]   in_reg;
  logic              skip_take;
  state_e            state;
  opcode_e           fetched_op, cur_op;

  assign fetched_op = opcode_e'(mem_rdata[DATA_W-1 -: OPC_W]);
  assign cur_op     = opcode_e'(ir[DATA_W-1 -: OPC_W]);

  acc_cpu_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .fetched_op(fetched_op), .cur_op(cur_op), .state(state)
  );

  acc_cpu_alu #(.DATA_W(DATA_W), .IO_W(IO_W)) i_alu (
    .op(cur_op), .cond(ir[COND_HI -: 2]), .ac(ac), .mbr(mbr), .in_byte(in_reg),
    .result(alu_res), .skip(skip_take)
  );

  acc_cpu_io #(.IO_W(IO_W)) i_io (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_load(state == ST_EXEC && cur_op == OP_OUT), .out_src(ac[IO_W-1:0]),
    .in_reg(in_reg), .out_data(out_data), .out_valid(out_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      ac  <= '0;
      mbr <= '0;
      ir  <= '0;
    end else begin
      case (state)
        ST_FETCH:    mar <= pc;
        ST_FETCH_RD: pc  <= pc + STEP;
        ST_DECODE: begin
          ir  <= mem_rdata;
          mar <= mem_rdata[ADDR_W-1:0];
        end
        ST_OPND_CAP: begin
          mbr <= mem_rdata;
          if (cur_op == OP_ADDIND) mar <= mem_rdata[ADDR_W-1:0];
        end
        ST_IND_CAP:  mbr <= mem_rdata;
        ST_EXEC: begin
          ac <= alu_res;
          case (cur_op)
            OP_STORE:  mbr <= ac;
            OP_CALL:   mbr <= DATA_W'(pc);
            OP_JMP:    pc  <= ir[ADDR_W-1:0];
            OP_JMPIND: pc  <= mbr[ADDR_W-1:0];
            OP_SKIP:   if (skip_take) pc <= pc + STEP;
            default:   ;
          endcase
        end
        ST_WRITE: begin
          if (cur_op == OP_CALL) begin
            ac <= DATA_W'(mar + STEP);
            pc <= mar + STEP;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (state == ST_WRITE);
  assign halted    = (state == ST_HALTED);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              out_valid,
  input logic [IO_W-1:0]   out_data,
  input logic              halted
);
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r11_data_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);

  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r12_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !out_valid));

  a_r12_halt_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(mem_addr));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W)) i_acc_cpu_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .out_valid(out_valid), .out_data(out_data), .halted(halted)
);

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;
  localparam int DW = 16, AW = 12, IW = 8, WORDS = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, mem_we, in_valid, out_valid, halted;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [IW-1:0] in_data, out_data;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .halted(halted)
  );

  // bench memory: one-cycle read latency, loader and clear share the process
  logic [DW-1:0] mem [WORDS];
  logic          ld_en, clr;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  logic [DW-1:0] ref_mem [WORDS];
  int  n_chk = 0, n_fail = 0;
  int  wq_a[$], wq_d[$], oq[$], got_out[$];
  int  exp_halt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic put(input int a, input int d);
    ref_mem[a] = DW'(d);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = DW'(d);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // behavioural instruction model with per-instruction cycle cost
  task automatic run_ref(input logic [7:0] inb);
    logic [15:0] ac = '0, w;
    logic [11:0] pc = '0, x;
    int c = 0;
    bit done = 0, take;
    wq_a.delete(); wq_d.delete(); oq.delete();
    exp_halt = -1;
    for (int step = 0; step < 1000 && !done; step++) begin
      w = ref_mem[pc]; pc = pc + 12'd1; x = w[11:0];
      case (w[15:12])
        4'h0: begin ref_mem[x] = {4'b0, pc}; wq_a.push_back(x); wq_d.push_back({4'b0, pc});
                    ac = {4'b0, x + 12'd1}; pc = x + 12'd1; c += 5; end
        4'h1: begin ac = ref_mem[x]; c += 6; end
        4'h2: begin ref_mem[x] = ac; wq_a.push_back(x); wq_d.push_back(ac); c += 5; end
        4'h3: begin ac = ac + ref_mem[x]; c += 6; end
        4'h4: begin ac = ac - ref_mem[x]; c += 6; end
        4'h5: begin ac = {8'b0, inb}; c += 4; end
        4'h6: begin oq.push_back(ac[7:0]); c += 4; end
        4'h7: begin exp_halt = c + 4; done = 1; end
        4'h8: begin
          case (w[11:10])
            2'b00: take = $signed(ac) < 0;
            2'b01: take = ac == 0;
            2'b10: take = $signed(ac) > 0;
            default: take = 0;
          endcase
          if (take) pc = pc + 12'd1;
          c += 4;
        end
        4'h9: begin pc = x; c += 4; end
        4'hA: begin ac = '0; c += 4; end
        4'hB: begin ac = ac + ref_mem[ref_mem[x][11:0]]; c += 8; end
        4'hC: begin pc = ref_mem[x][11:0]; c += 6; end
        default: c += 4;
      endcase
    end
  endtask

  task automatic run_prog(input int n);
    int cyc = 0, post = 0;
    bit seen = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    clear_all();
    if (n == 1) begin
      put('h00, 'h1040); put('h01, 'h3041); put('h02, 'h2050); put('h03, 'h4042);
      put('h04, 'h2051); put('h05, 'h8800); put('h06, 'h7000); put('h07, 'hA000);
      put('h08, 'h8400); put('h09, 'h7000); put('h0A, 'h4041); put('h0B, 'h8000);
      put('h0C, 'h7000); put('h0D, 'h8C00); put('h0E, 'h2052); put('h0F, 'h8400);
      put('h10, 'h9020); put('h11, 'h7000); put('h20, 'h3043); put('h21, 'h2053);
      put('h22, 'hD000); put('h23, 'h8800); put('h24, 'h7000);
      put('h40, 'h7FFF); put('h41, 'h0001); put('h42, 'h0001); put('h43, 'hFFFF);
    end else begin
      put('h00, 'h5000); put('h01, 'h6000); put('h02, 'hB030); put('h03, 'h6000);
      put('h04, 'h0060); put('h05, 'h2070); put('h06, 'hE000); put('h07, 'hF000);
      put('h08, 'hC032); put('h61, 'h6000); put('h62, 'hC060);
      put('hA0, 'hA000); put('hA1, 'h6000); put('hA2, 'h7000);
      put('h30, 'h0031); put('h31, 'h0123); put('h32, 'h00A0);
    end
    @(negedge clk);
    // R1 reset state (also R12: halted clears on reset after a prior halt)
    chk(!mem_we && !out_valid, "R1", "strobes in reset", {mem_we, out_valid}, 0);
    chk(!halted, "R12", "halted cleared by reset", halted, 0);
    chk(mem_addr == 0 && out_data == 0, "R1", "addr/out in reset", {mem_addr, out_data}, 0);
    run_ref(8'hA5);
    got_out.delete();
    rst_n = 1'b1;
    if (n == 2) begin in_valid = 1'b1; in_data = 8'h3C; end
    for (int k = 0; k < 4000 && post < 20; k++) begin
      @(negedge clk);
      cyc++;
      if (n == 2 && cyc == 1) in_data = 8'hA5;
      if (n == 2 && cyc == 2) in_valid = 1'b0;
      if (cyc == 1) chk(mem_addr == 0, "R1", "first fetch address", mem_addr, 0);
      chk(halted == (cyc >= exp_halt), "R13", "halted timing", halted, cyc >= exp_halt);
      if (mem_we) begin
        if (wq_a.size() == 0) chk(0, "R12", "unexpected write", mem_addr, 0);
        else begin
          chk(mem_addr == wq_a[0] && mem_wdata == wq_d[0], "R2", "write addr/data",
              {mem_addr, mem_wdata}, {wq_a[0][11:0], wq_d[0][15:0]});
          void'(wq_a.pop_front()); void'(wq_d.pop_front());
        end
      end
      if (out_valid) begin
        got_out.push_back(out_data);
        if (oq.size() == 0) chk(0, "R12", "unexpected output", out_data, 0);
        else begin
          chk(out_data == oq[0], "R11", "output byte", out_data, oq[0]);
          void'(oq.pop_front());
        end
      end
      if (halted) begin seen = 1; post++; end
    end
    chk(seen, "R12", "watchdog: halt reached", seen, 1);
    chk(wq_a.size() == 0 && oq.size() == 0, "R4", "all expected writes/outputs seen",
        wq_a.size() + oq.size(), 0);
    for (int i = 0; i < 256; i++)
      if (mem[i] != ref_mem[i]) chk(0, "R2", $sformatf("memory word %0h", i), mem[i], ref_mem[i]);
    n_chk++;
    if (n == 1) begin
      chk(mem['h50] == 16'h8000, "R3", "add wraps to negative", mem['h50], 16'h8000);
      chk(mem['h51] == 16'h7FFF, "R3", "subtract wraps back", mem['h51], 16'h7FFF);
      chk(mem['h52] == 16'hFFFF, "R5", "skip codes 10/01/00/11", mem['h52], 16'hFFFF);
      chk(mem['h53] == 16'hFFFE, "R6", "direct jump then add wrap", mem['h53], 16'hFFFE);
      chk(mem['h06] == 16'h7000, "R4", "no stray write", mem['h06], 16'h7000);
    end else begin
      chk(got_out.size() == 4, "R11", "output count", got_out.size(), 4);
      if (got_out.size() == 4) begin
        chk(got_out[0] == 'hA5, "R10", "last capture wins, zero-extended", got_out[0], 'hA5);
        chk(got_out[1] == 'hC8, "R7", "indirect add", got_out[1], 'hC8);
        chk(got_out[2] == 'h61, "R8", "call sets AC to X+1", got_out[2], 'h61);
        chk(got_out[3] == 'h00, "R9", "clear", got_out[3], 'h00);
      end
      chk(mem['h60] == 16'h0005, "R8", "return address stored", mem['h60], 5);
      chk(mem['h70] == 16'h0061, "R6", "indirect jump returned", mem['h70], 'h61);
      chk(mem['h06] == 16'hE000 && mem['h07] == 16'hF000, "R9", "no-op words intact",
          {mem['h06], mem['h07]}, 32'hE000F000);
      chk(out_data == 8'h00, "R11", "out_data holds", out_data, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; clr = 1'b0; in_valid = 1'b0; in_data = '0;
    ld_addr = '0; ld_data = '0;
    repeat (2) @(negedge clk);
    run_prog(1);
    run_prog(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule